// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block stores a small set of words and finds them by content instead of by address. Software-side logic, or a neighbouring block, first loads a comparand and a mask into two internal registers. A search then compares every stored word with the comparand at the same moment. Only the bit positions enabled by the mask take part. The per-word outcome is captured in a hit register with one bit per word.

Words are inserted without an address: the block places each new word in the lowest-numbered empty slot and reports when no slot is left. After a search, the hits are drained one per step-pulse, in ascending slot order. Each step presents the stored word and its slot number. A purge command empties every slot currently flagged in the hit register, which frees those slots for later inserts.

Top module: `mask_cam`

## Requirements
- R1: After a synchronous reset every slot is empty, the hit register is zero, `done` is 1, `full` is 0 and `rd_valid` is 0.
- R2: An empty slot never produces a hit, so a search over an empty memory yields an all-zero `match_vec`, whatever the comparand and mask.
- R3: `wr_en` stores `wr_data` in the lowest-numbered empty slot and marks that slot occupied; slot numbers start at 0.
- R4: `full` is 1 exactly when every slot is occupied; an insert while `full` is 1 changes no slot.
- R5: On `search`, bit i of `match_vec` becomes 1 one cycle later exactly when slot i is occupied and, for every bit position j where the mask bit j is 1, stored bit j equals comparand bit j. The comparison uses the comparand and mask held before that clock edge.
- R6: A mask bit of 0 excludes that position from the compare, so an all-zero mask hits every occupied slot and an all-ones mask requires full equality.
- R7: Each `next` pulse, while hits remain, sets `rd_valid` and presents the lowest-numbered remaining hit on `rd_index` and its word on `rd_data`, then clears that hit bit.
- R8: `done` is 1 when no hit bits remain; a `next` pulse with no hits remaining drives `rd_valid` to 0.
- R9: `inval` empties every slot whose hit bit is set and clears the hit register; the emptied slots are then reused by later inserts in lowest-first order. When several commands share a cycle, the one acted on is the first of search, inval, wr_en, next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arg_load | input | 1 | Load `arg_in` into the comparand register |
| arg_in | input | WIDTH | Comparand value |
| key_load | input | 1 | Load `key_in` into the mask register |
| key_in | input | WIDTH | Mask value, 1 = compare this bit |
| search | input | 1 | Compare all slots and capture hits |
| wr_en | input | 1 | Insert `wr_data` into the lowest empty slot |
| wr_data | input | WIDTH | Word to insert |
| inval | input | 1 | Empty all slots flagged in the hit register |
| next | input | 1 | Present the next hit |
| full | output | 1 | All slots occupied |
| match_vec | output | WORDS | Hit register, one bit per slot |
| rd_valid | output | 1 | `rd_data`/`rd_index` hold a hit from the last step |
| rd_data | output | WIDTH | Word of the presented hit |
| rd_index | output | IW | Slot number of the presented hit |
| done | output | 1 | No hit bits remain |

## Verification
The bench builds the block with four slots of four bits. At that size every comparand paired with every mask (256 combinations) can be searched against a filled memory that holds a repeated word. Each search is followed by a complete drain, so the masked compare, the duplicate-hit ordering and the end-of-drain behaviour are all checked against values the bench works out arithmetically. The small depth also makes the full condition, the dropped insert and the reuse of purged slots quick to reach.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_SEARCH,
    OP_PURGE,
    OP_INSERT,
    OP_STEP
  } cam_op_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cam_lowest.sv
module cam_lowest #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/cam_store.sv
module cam_store #(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  parameter int IW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_go,
  input  logic [IW-1:0]    wr_slot,
  input  logic [WIDTH-1:0] wr_word,
  input  logic [WORDS-1:0] clr_vec,
  input  logic [WIDTH-1:0] cmp_arg,
  input  logic [WIDTH-1:0] cmp_key,
  input  logic [IW-1:0]    rd_slot,
  output logic [WIDTH-1:0] rd_word,
  output logic [WORDS-1:0] hit_vec,
  output logic [WORDS-1:0] occ_vec
);

  logic [WIDTH-1:0] mem [WORDS];
  logic [WORDS-1:0] occ_q;

  // word storage: no reset, one write port
  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_slot] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (wr_go && (wr_slot == IW'(i))) occ_q[i] <= 1'b1;
        else if (clr_vec[i])              occ_q[i] <= 1'b0;
      end
    end
  end

  // per-word masked equality: XNOR per bit, AND across enabled bits
  for (genvar g = 0; g < WORDS; g++) begin : g_cmp
    logic [WIDTH-1:0] same;
    assign same       = ~(mem[g] ^ cmp_arg) | ~cmp_key;
    assign hit_vec[g] = occ_q[g] & (&same);
  end

  assign rd_word = mem[rd_slot];
  assign occ_vec = occ_q;

endmodule

// File: rtl/mask_cam.sv
module mask_cam
  import cam_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int IW   = cam_pkg::idx_bits(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arg_load,
  input  logic [WIDTH-1:0] arg_in,
  input  logic             key_load,
  input  logic [WIDTH-1:0] key_in,
  input  logic             search,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             inval,
  input  logic             next,
  output logic             full,
  output logic [WORDS-1:0] match_vec,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic [IW-1:0]    rd_index,
  output logic             done
);

  cam_op_e          op;
  logic [WIDTH-1:0] arg_q, key_q;
  logic [WORDS-1:0] match_q;
  logic [WORDS-1:0] hit_vec, valid_vec;
  logic [WIDTH-1:0] rd_word;
  logic [IW-1:0]    free_idx, hit_idx;
  logic             free_any, hit_any;
  logic             wr_go;
  logic [WORDS-1:0] clr_vec;

  always_comb begin
    if (search)     op = OP_SEARCH;
    else if (inval) op = OP_PURGE;
    else if (wr_en) op = OP_INSERT;
    else if (next)  op = OP_STEP;
    else            op = OP_IDLE;
  end

  cam_lowest #(.N(WORDS), .IW(IW)) u_free (
    .req(~valid_vec), .idx(free_idx), .any(free_any)
  );

  cam_lowest #(.N(WORDS), .IW(IW)) u_hit (
    .req(match_q), .idx(hit_idx), .any(hit_any)
  );

  assign wr_go   = (op == OP_INSERT) && free_any;
  assign clr_vec = (op == OP_PURGE) ? match_q : '0;

  cam_store #(.WORDS(WORDS), .WIDTH(WIDTH), .IW(IW)) u_store (
    .clk(clk), .rst(rst),
    .wr_go(wr_go), .wr_slot(free_idx), .wr_word(wr_data),
    .clr_vec(clr_vec),
    .cmp_arg(arg_q), .cmp_key(key_q),
    .rd_slot(hit_idx), .rd_word(rd_word),
    .hit_vec(hit_vec), .occ_vec(valid_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arg_q    <= '0;
      key_q    <= '0;
      match_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_index <= '0;
    end else begin
      if (arg_load) arg_q <= arg_in;
      if (key_load) key_q <= key_in;
      case (op)
        OP_SEARCH: begin
          match_q  <= hit_vec;
          rd_valid <= 1'b0;
        end
        OP_PURGE: begin
          match_q  <= '0;
          rd_valid <= 1'b0;
        end
        OP_STEP: begin
          if (hit_any) begin
            rd_valid         <= 1'b1;
            rd_data          <= rd_word;
            rd_index         <= hit_idx;
            match_q[hit_idx] <= 1'b0;
          end else begin
            rd_valid <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign match_vec = match_q;
  assign full      = ~free_any;
  assign done      = ~hit_any;

endmodule

// File: rtl/cam_checker.sv
module cam_checker #(
  parameter int WORDS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             search,
  input logic             inval,
  input logic             wr_en,
  input logic             next,
  input logic             full,
  input logic             rd_valid,
  input logic [WORDS-1:0] valid,
  input logic [WORDS-1:0] match_vec
);

  logic step_only, ins_only;
  assign step_only = next && !search && !inval && !wr_en;
  assign ins_only  = wr_en && !search && !inval;

  p_hits_occupied_r2: assert property (@(posedge clk) disable iff (rst)
    (match_vec & ~valid) == '0);

  p_insert_one_r3: assert property (@(posedge clk) disable iff (rst)
    (ins_only && !full) |=> ($countones(valid) == $countones($past(valid)) + 1));

  p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (ins_only && full) |=> $stable(valid));

  p_step_shrink_r7: assert property (@(posedge clk) disable iff (rst)
    (step_only && (match_vec != '0)) |=>
      (rd_valid && ($countones(match_vec) + 1 == $countones($past(match_vec)))));

  p_step_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (step_only && (match_vec == '0)) |=> !rd_valid);

  p_purge_r9: assert property (@(posedge clk) disable iff (rst)
    (inval && !search) |=> (((valid & $past(match_vec)) == '0) && (match_vec == '0)));

endmodule

bind mask_cam cam_checker #(.WORDS(WORDS)) u_cam_checker (
  .clk(clk), .rst(rst),
  .search(search), .inval(inval), .wr_en(wr_en), .next(next),
  .full(full), .rd_valid(rd_valid),
  .valid(valid_vec), .match_vec(match_vec)
);

// File: tb/test_mask_cam.sv
module test_mask_cam;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 4;
  localparam int WIDTH = 4;
  localparam int IW    = 2;

  logic             clk = 1'b0;
  logic             rst;
  logic             arg_load, key_load, search, wr_en, inval, next;
  logic [WIDTH-1:0] arg_in, key_in, wr_data;
  logic             full, rd_valid, done;
  logic [WORDS-1:0] match_vec;
  logic [WIDTH-1:0] rd_data;
  logic [IW-1:0]    rd_index;

  int checks = 0;
  int errors = 0;

  logic [WIDTH-1:0] mdl_data [WORDS];
  logic [WORDS-1:0] mdl_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_cam #(.WORDS(WORDS), .WIDTH(WIDTH)) i_mask_cam (
    .clk(clk), .rst(rst),
    .arg_load(arg_load), .arg_in(arg_in),
    .key_load(key_load), .key_in(key_in),
    .search(search), .wr_en(wr_en), .wr_data(wr_data),
    .inval(inval), .next(next),
    .full(full), .match_vec(match_vec),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_index(rd_index),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    arg_load = 0; key_load = 0; search = 0; wr_en = 0; inval = 0; next = 0;
  endtask

  function automatic logic [WORDS-1:0] expect_hits(input logic [WIDTH-1:0] a,
                                                   input logic [WIDTH-1:0] k);
    logic [WORDS-1:0] v;
    for (int i = 0; i < WORDS; i++)
      v[i] = mdl_valid[i] && ((mdl_data[i] & k) == (a & k));
    return v;
  endfunction

  task automatic do_write(input logic [WIDTH-1:0] d);
    int slot;
    slot = -1;
    for (int i = WORDS - 1; i >= 0; i--) if (!mdl_valid[i]) slot = i;
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); idle_inputs();
    if (slot >= 0) begin
      mdl_valid[slot] = 1'b1;
      mdl_data[slot]  = d;
    end
    check(full == (&mdl_valid), "R4 full flag", full, &mdl_valid);
  endtask

  task automatic do_search(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k,
                           input string req);
    logic [WORDS-1:0] e;
    @(negedge clk); arg_load = 1; arg_in = a; key_load = 1; key_in = k;
    @(negedge clk); idle_inputs(); search = 1;
    @(negedge clk); idle_inputs();
    e = expect_hits(a, k);
    check(match_vec == e, req, match_vec, e);
  endtask

  // drain all hits; checks ascending order, data, index, done and empty step
  task automatic drain(input logic [WORDS-1:0] e);
    for (int i = 0; i < WORDS; i++) begin
      if (e[i]) begin
        @(negedge clk); next = 1;
        @(negedge clk); idle_inputs();
        check(rd_valid && rd_index == IW'(i) && rd_data == mdl_data[i],
              "R7 readout", {rd_valid, rd_index, rd_data}, {1'b1, IW'(i), mdl_data[i]});
      end
    end
    check(done == 1'b1, "R8 done after drain", done, 1);
    @(negedge clk); next = 1;
    @(negedge clk); idle_inputs();
    check(rd_valid == 1'b0, "R8 step with no hits", rd_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    arg_in = 0; key_in = 0; wr_data = 0;
    mdl_valid = '0;
    for (int i = 0; i < WORDS; i++) mdl_data[i] = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check(match_vec == '0 && done && !full && !rd_valid, "R1 reset state",
          {match_vec, done, full, rd_valid}, {4'b0, 1'b1, 1'b0, 1'b0});

    // R2 empty memory never hits
    do_search(4'h0, 4'hF, "R2 empty all-ones mask");
    do_search(4'h5, 4'h0, "R2 empty zero mask");

    // R3 fill lowest-first, with a duplicate word
    do_write(4'h3);
    do_write(4'hA);
    do_write(4'h3);
    do_write(4'h6);
    do_search(4'h0, 4'h0, "R6 zero mask hits all");
    check(match_vec == 4'hF, "R3 all slots filled", match_vec, 4'hF);
    drain(4'hF);

    // R4 insert while full is dropped
    do_write(4'hF);
    do_search(4'hF, 4'hF, "R4 dropped word absent");
    check(match_vec == '0, "R4 no slot changed", match_vec, 0);

    // R5 R6 exhaustive comparand x mask sweep with drain
    for (int a = 0; a < 16; a++) begin
      for (int k = 0; k < 16; k++) begin
        do_search(WIDTH'(a), WIDTH'(k), "R5 masked compare");
        drain(expect_hits(WIDTH'(a), WIDTH'(k)));
      end
    end

    // R9 purge slots holding 3 (slots 0 and 2)
    do_search(4'h3, 4'hF, "R5 exact match");
    @(negedge clk); inval = 1;
    @(negedge clk); idle_inputs();
    mdl_valid[0] = 0; mdl_valid[2] = 0;
    check(match_vec == '0 && done, "R9 hits cleared", match_vec, 0);
    check(!full, "R9 slots freed", full, 0);
    do_search(4'h0, 4'h0, "R9 purged slots gone");
    check(match_vec == 4'b1010, "R9 survivors", match_vec, 4'b1010);

    // R9 R3 reuse lowest freed slot
    do_write(4'hC);
    do_search(4'hC, 4'hF, "R3 reuse search");
    @(negedge clk); next = 1;
    @(negedge clk); idle_inputs();
    check(rd_valid && rd_index == 2'd0 && rd_data == 4'hC, "R3 reuse slot 0",
          {rd_index, rd_data}, {2'd0, 4'hC});
    do_write(4'h9);
    check(full, "R4 full again", full, 1);
    do_search(4'h9, 4'hF, "R3 second reuse");
    drain(4'b0100);

    // R9 priority: search wins over next in the same cycle
    do_search(4'h0, 4'h0, "R9 priority setup");
    @(negedge clk); search = 1; next = 1;
    @(negedge clk); idle_inputs();
    check(match_vec == 4'hF && !rd_valid, "R9 search over next",
          {match_vec, rd_valid}, {4'hF, 1'b0});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule